// File: doc/BRIEF.md
# Reset-Phase Pad Control Sequencer

This block decides, for every pad in an I/O bank, whether the pad is driven and with what value while the device passes through a global reset and the period that follows it. Each pad carries a fixed three-bit group code. The code selects one of several policies. A pad can follow its default peripheral throughout. It can float during reset so that external straps can be read. It can stay powered down until software releases it. It can float during reset and then drive low, drive high or drive a fixed filler pattern. Or it can simply stay floating until its peripheral is enabled.

Any one of several active-low reset sources pulls the block into reset at once, with no clock edge needed. Release is synchronized through two flops. After that the internal reset-out phase stays asserted for `HOLD_CYC` further cycles under a small state machine with four states. `ST_RST` is entered asynchronously whenever a source asserts. `ST_RST -> ST_HOLD` happens on the first edge after the synchronized release. `ST_HOLD -> ST_REL` happens when the hold counter reaches `HOLD_CYC-1`. `ST_REL -> ST_RUN` happens unconditionally one cycle later. `ST_RUN` stays put until the next reset. Reset-out reads high in `ST_REL` and `ST_RUN`. During `ST_REL` the two-flop-synchronized pad inputs of the strap pads are loaded into a configuration word. That word then holds until the next reset. A small write port sets three per-pad registers: pin-mux select, power enable and peripheral enable.

Top module: `pad_rst_ctrl`

## Requirements
- R1: While any bit of `rst_src_n` is 0, `rstout_n` is 0 and every pad whose group code is 1..7 has `pad_oe` = 0, with no clock edge needed. Whenever `pad_oe[i]` is 0, `pad_out[i]` is 0.
- R2: After all reset sources are 1, `rstout_n` is still 0 following rising edge `HOLD_CYC+2` and is 1 following rising edge `HOLD_CYC+3`. It then stays 1 until a source asserts again.
- R3: A pad with group code 0 drives the default request (`dflt_oe`, `dflt_out`) while `rstout_n` is 0. Afterwards it drives the selected request: the alternate request (`alt_oe`, `alt_out`) when its mux bit is 1, otherwise the default request.
- R4: A pad with group code 1 (strap pad) is undriven while `rstout_n` is 0 and drives the selected request afterwards.
- R5: `cfg_word[i]` is 0 in reset and for every pad whose group code is not 1. For a strap pad it takes the value of `pad_in[i]`, through a two-flop synchronizer, on the rising edge that follows the first cycle with `rstout_n` = 1. It is therefore still 0 in that first cycle.
- R6: After capture, `cfg_word` does not change, whatever `pad_in` does, until the next reset.
- R7: A pad with group code 2 is undriven until both its power-enable bit and its mux bit are 1. From then on it drives the alternate request.
- R8: After reset-out releases, a pad with group code 3 drives 0 and a pad with group code 4 drives 1, each with `pad_oe` = 1, until its peripheral-enable bit is 1. From then on it drives the selected request.
- R9: After reset-out releases, a pad with group code 5 drives `pad_oe` = 1 with `pad_out` equal to bit 0 of the pad index (odd pads 1, even pads 0) until its peripheral-enable bit is 1. From then on it drives the selected request.
- R10: A pad with group code 6, or the reserved code 7, is undriven until its peripheral-enable bit is 1 after release. From then on it drives the selected request.
- R11: A write (`wr_en` = 1) loads `wr_data` into the mux register for `wr_sel` = 0, the power-enable register for 1 and the peripheral-enable register for 2; `wr_sel` = 3 writes nothing. The new value affects the pads from the cycle after the accepting edge. Writes while `rstout_n` is 0 are dropped, and all three registers are 0 after every reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_src_n | input | NUM_SRC | Active-low global reset sources; any low bit resets |
| pad_group | input | 3*NUM_PADS | Static group code per pad, pad i at bits [3i+2:3i] |
| pad_in | input | NUM_PADS | Values observed on the pads (strap inputs) |
| dflt_oe | input | NUM_PADS | Default peripheral drive-enable request |
| dflt_out | input | NUM_PADS | Default peripheral drive value |
| alt_oe | input | NUM_PADS | Alternate peripheral drive-enable request |
| alt_out | input | NUM_PADS | Alternate peripheral drive value |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mux, 1 power enable, 2 peripheral enable |
| wr_data | input | NUM_PADS | Write data, one bit per pad |
| pad_oe | output | NUM_PADS | Pad output enable |
| pad_out | output | NUM_PADS | Pad output value |
| cfg_word | output | NUM_PADS | Captured strap values |
| rstout_n | output | 1 | Reset-out phase, low while pads are held |

## Verification
Pad enables and values respond to a source assertion within the same cycle, and to a register write right after the edge that accepts it. The bench therefore samples one nanosecond after the relevant edge, or after the asynchronous change, with no further edge in between. Reset-out is checked in the cycle after edge `HOLD_CYC+2`, where it must still be low, and after edge `HOLD_CYC+3`, where it must be high. That is two synchronizer flops, one state step out of `ST_RST` and `HOLD_CYC` hold cycles. The configuration word is checked as still zero in the first reset-out-high cycle and as loaded one edge later. A second reset, with a different source and different strap values, repeats all of this.

// File: rtl/pad_rst_pkg.sv
`timescale 1ns/1ps
package pad_rst_pkg;

    // Per-pad behaviour class, fixed by wiring
    typedef enum logic [2:0] {
        GRP_DFLT  = 3'd0,   // default peripheral, also during reset
        GRP_BOOT  = 3'd1,   // strap pad, floats during reset
        GRP_PWDN  = 3'd2,   // powered down until power + mux set
        GRP_ZLO   = 3'd3,   // floats, then drives 0
        GRP_ZHI   = 3'd4,   // floats, then drives 1
        GRP_ZINV  = 3'd5,   // floats, then filler pattern
        GRP_ZHOLD = 3'd6,   // floats until enabled
        GRP_RSVD  = 3'd7    // handled like GRP_ZHOLD
    } pad_grp_e;

    typedef enum logic [1:0] {
        ST_RST  = 2'd0,
        ST_HOLD = 2'd1,
        ST_REL  = 2'd2,
        ST_RUN  = 2'd3
    } seq_st_e;

    localparam logic [1:0] SEL_MUX = 2'd0;
    localparam logic [1:0] SEL_PWR = 2'd1;
    localparam logic [1:0] SEL_EN  = 2'd2;

endpackage

// File: rtl/pad_rst_seq.sv
`timescale 1ns/1ps
module pad_rst_seq
    import pad_rst_pkg::*;
#(
    parameter int HOLD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic rstout_n,
    output logic cap_en
);

    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC - 1);

    seq_st_e          st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_RST;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    // transitions
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            ST_RST: begin
                st_nx  = ST_HOLD;
                cnt_nx = '0;
            end
            ST_HOLD: begin
                if (cnt == CNT_LAST) begin
                    st_nx = ST_REL;
                end else begin
                    cnt_nx = cnt + CNT_W'(1);
                end
            end
            ST_REL:  st_nx = ST_RUN;
            ST_RUN:  st_nx = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        rstout_n = 1'b0;
        cap_en   = 1'b0;
        unique case (st)
            ST_RST, ST_HOLD: rstout_n = 1'b0;
            ST_REL: begin
                rstout_n = 1'b1;
                cap_en   = 1'b1;
            end
            ST_RUN:  rstout_n = 1'b1;
        endcase
    end

    // R2: capture state lasts exactly one cycle
    p_rel_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_REL) |=> (st == ST_RUN));

    // R2: counter never runs past the hold window
    p_hold_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> (cnt < CNT_W'(HOLD_CYC)));

    // R2: once running, stays running until reset
    p_run_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |=> (st == ST_RUN));

endmodule

// File: rtl/pad_rst_regs.sv
`timescale 1ns/1ps
module pad_rst_regs
    import pad_rst_pkg::*;
#(
    parameter int NUM_PADS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ok,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [NUM_PADS-1:0] wr_data,
    output logic [NUM_PADS-1:0] mux_sel,
    output logic [NUM_PADS-1:0] pwr_on,
    output logic [NUM_PADS-1:0] periph_en
);

    logic do_wr;
    assign do_wr = wr_en && wr_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mux_sel   <= '0;
            pwr_on    <= '0;
            periph_en <= '0;
        end else if (do_wr) begin
            unique case (wr_sel)
                SEL_MUX: mux_sel   <= wr_data;
                SEL_PWR: pwr_on    <= wr_data;
                SEL_EN:  periph_en <= wr_data;
                default: ;
            endcase
        end
    end

    // R11: nothing is written while reset-out is low
    p_wr_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable({mux_sel, pwr_on, periph_en}));

endmodule

// File: rtl/pad_rst_strap.sv
`timescale 1ns/1ps
module pad_rst_strap #(
    parameter int NUM_PADS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_en,
    input  logic [NUM_PADS-1:0] pad_in,
    input  logic [NUM_PADS-1:0] boot_mask,
    output logic [NUM_PADS-1:0] cfg_word
);

    logic [NUM_PADS-1:0] sync_a, sync_b;

    // two-stage synchronizer on raw pad levels
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= '0;
            sync_b <= '0;
        end else begin
            sync_a <= pad_in;
            sync_b <= sync_a;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_word <= '0;
        end else if (cap_en) begin
            cfg_word <= sync_b & boot_mask;
        end
    end

    // R6: word only moves on the capture cycle
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(cfg_word));

endmodule

// File: rtl/pad_rst_lane.sv
`timescale 1ns/1ps
module pad_rst_lane
    import pad_rst_pkg::*;
#(
    parameter int IDX = 0
) (
    input  pad_grp_e grp,
    input  logic     rel,
    input  logic     ms,
    input  logic     pw,
    input  logic     en,
    input  logic     doe,
    input  logic     dout,
    input  logic     aoe,
    input  logic     aout,
    output logic     oe,
    output logic     out
);

    localparam logic FILL_BIT = ((IDX % 2) == 1);

    logic sel_oe, sel_val;
    logic drv_oe, drv_val;

    always_comb begin
        sel_oe  = ms ? aoe  : doe;
        sel_val = ms ? aout : dout;
        drv_oe  = 1'b0;
        drv_val = 1'b0;
        unique case (grp)
            GRP_DFLT: begin
                drv_oe  = rel ? sel_oe  : doe;
                drv_val = rel ? sel_val : dout;
            end
            GRP_BOOT: begin
                if (rel) begin
                    drv_oe  = sel_oe;
                    drv_val = sel_val;
                end
            end
            GRP_PWDN: begin
                if (rel && pw && ms) begin
                    drv_oe  = aoe;
                    drv_val = aout;
                end
            end
            GRP_ZLO, GRP_ZHI, GRP_ZINV: begin
                if (rel && en) begin
                    drv_oe  = sel_oe;
                    drv_val = sel_val;
                end else if (rel) begin
                    drv_oe  = 1'b1;
                    drv_val = (grp == GRP_ZHI) ? 1'b1
                            : (grp == GRP_ZINV) ? FILL_BIT : 1'b0;
                end
            end
            GRP_ZHOLD, GRP_RSVD: begin
                if (rel && en) begin
                    drv_oe  = sel_oe;
                    drv_val = sel_val;
                end
            end
        endcase
        oe  = drv_oe;
        out = drv_oe & drv_val;
    end

endmodule

// File: rtl/pad_rst_ctrl.sv
`timescale 1ns/1ps
module pad_rst_ctrl
    import pad_rst_pkg::*;
#(
    parameter int NUM_PADS = 8,
    parameter int NUM_SRC  = 3,
    parameter int HOLD_CYC = 8
) (
    input  logic                  clk,
    input  logic [NUM_SRC-1:0]    rst_src_n,
    input  logic [3*NUM_PADS-1:0] pad_group,
    input  logic [NUM_PADS-1:0]   pad_in,
    input  logic [NUM_PADS-1:0]   dflt_oe,
    input  logic [NUM_PADS-1:0]   dflt_out,
    input  logic [NUM_PADS-1:0]   alt_oe,
    input  logic [NUM_PADS-1:0]   alt_out,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [NUM_PADS-1:0]   wr_data,
    output logic [NUM_PADS-1:0]   pad_oe,
    output logic [NUM_PADS-1:0]   pad_out,
    output logic [NUM_PADS-1:0]   cfg_word,
    output logic                  rstout_n
);

    // any source low forces reset; release goes through two flops
    logic src_all_n;
    logic rsync_a, rsync_b;
    logic core_rst_n;

    assign src_all_n = &rst_src_n;

    always_ff @(posedge clk or negedge src_all_n) begin
        if (!src_all_n) begin
            rsync_a <= 1'b0;
            rsync_b <= 1'b0;
        end else begin
            rsync_a <= 1'b1;
            rsync_b <= rsync_a;
        end
    end
    assign core_rst_n = rsync_b;

    logic cap_en;

    pad_rst_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
        .clk      (clk),
        .rst_n    (core_rst_n),
        .rstout_n (rstout_n),
        .cap_en   (cap_en)
    );

    logic [NUM_PADS-1:0] mux_sel, pwr_on, periph_en;

    pad_rst_regs #(.NUM_PADS(NUM_PADS)) u_regs (
        .clk       (clk),
        .rst_n     (core_rst_n),
        .wr_ok     (rstout_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .mux_sel   (mux_sel),
        .pwr_on    (pwr_on),
        .periph_en (periph_en)
    );

    logic [NUM_PADS-1:0] boot_mask, dflt_mask, zlo_mask;

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_lane
        pad_grp_e grp_i;
        assign grp_i        = pad_grp_e'(pad_group[3*i +: 3]);
        assign boot_mask[i] = (grp_i == GRP_BOOT);
        assign dflt_mask[i] = (grp_i == GRP_DFLT);
        assign zlo_mask[i]  = (grp_i == GRP_ZLO);

        pad_rst_lane #(.IDX(i)) u_lane (
            .grp  (grp_i),
            .rel  (rstout_n),
            .ms   (mux_sel[i]),
            .pw   (pwr_on[i]),
            .en   (periph_en[i]),
            .doe  (dflt_oe[i]),
            .dout (dflt_out[i]),
            .aoe  (alt_oe[i]),
            .aout (alt_out[i]),
            .oe   (pad_oe[i]),
            .out  (pad_out[i])
        );
    end

    pad_rst_strap #(.NUM_PADS(NUM_PADS)) u_strap (
        .clk       (clk),
        .rst_n     (core_rst_n),
        .cap_en    (cap_en),
        .pad_in    (pad_in),
        .boot_mask (boot_mask),
        .cfg_word  (cfg_word)
    );

    // R4: strap pads float for the whole reset-out phase
    p_boot_float_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
        !rstout_n |-> ((pad_oe & boot_mask) == '0));

    // R3: default pads track the default request during reset-out
    p_dflt_track_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
        !rstout_n |-> ((pad_oe & dflt_mask) == (dflt_oe & dflt_mask)));

    // R8: drive-low pads hold 0 until their peripheral is enabled
    p_zlow_hold_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
        rstout_n |-> (((pad_oe & zlo_mask & ~periph_en) == (zlo_mask & ~periph_en))
                   && ((pad_out & zlo_mask & ~periph_en) == '0)));

endmodule

// File: tb/pad_rst_ctrl_tb.sv
`timescale 1ns/1ps
module pad_rst_ctrl_tb;

    localparam int NP = 10;
    localparam int NS = 3;
    localparam int H  = 8;

    localparam logic [2:0] GRP [NP] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4,
                                        3'd5, 3'd5, 3'd1, 3'd6, 3'd7};

    // fields: mux, pwr, en, dflt_oe, dflt_out, alt_oe, alt_out
    localparam int NV = 6;
    localparam logic [7*NP-1:0] VEC [NV] = '{
        {10'h000, 10'h000, 10'h000, 10'h3FF, 10'h155, 10'h000, 10'h3FF},
        {10'h3FF, 10'h000, 10'h000, 10'h3FF, 10'h000, 10'h3FF, 10'h2AA},
        {10'h3FF, 10'h3FF, 10'h000, 10'h000, 10'h000, 10'h3FF, 10'h3FF},
        {10'h000, 10'h3FF, 10'h3FF, 10'h3FF, 10'h0F0, 10'h000, 10'h000},
        {10'h155, 10'h004, 10'h3FF, 10'h2AA, 10'h3FF, 10'h155, 10'h0CC},
        {10'h004, 10'h000, 10'h000, 10'h3FF, 10'h3FF, 10'h3FF, 10'h3FF}
    };

    logic                clk = 1'b0;
    logic [NS-1:0]       rst_src_n;
    logic [3*NP-1:0]     pad_group;
    logic [NP-1:0]       pad_in, dflt_oe, dflt_out, alt_oe, alt_out, wr_data;
    logic                wr_en;
    logic [1:0]          wr_sel;
    logic [NP-1:0]       pad_oe, pad_out, cfg_word;
    logic                rstout_n;

    logic [NP-1:0] m_mux, m_pwr, m_en;
    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    pad_rst_ctrl #(.NUM_PADS(NP), .NUM_SRC(NS), .HOLD_CYC(H)) u_dut (
        .clk(clk), .rst_src_n(rst_src_n), .pad_group(pad_group), .pad_in(pad_in),
        .dflt_oe(dflt_oe), .dflt_out(dflt_out), .alt_oe(alt_oe), .alt_out(alt_out),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pad_oe(pad_oe), .pad_out(pad_out), .cfg_word(cfg_word), .rstout_n(rstout_n)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [NP-1:0] data);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        tick();
        wr_en   = 1'b0;
    endtask

    function automatic string req_of(input logic [2:0] g);
        case (g)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R7";
            3'd3, 3'd4: return "R8";
            3'd5: return "R9";
            default: return "R10";
        endcase
    endfunction

    // expected {oe, out} for pad i from the requirements
    function automatic logic [1:0] model(input int i, input logic rel);
        logic [2:0] g;
        logic soe, sval, oe, v;
        g    = GRP[i];
        soe  = m_mux[i] ? alt_oe[i]  : dflt_oe[i];
        sval = m_mux[i] ? alt_out[i] : dflt_out[i];
        oe = 1'b0;
        v  = 1'b0;
        case (g)
            3'd0: begin oe = rel ? soe : dflt_oe[i]; v = rel ? sval : dflt_out[i]; end
            3'd1: if (rel) begin oe = soe; v = sval; end
            3'd2: if (rel && m_pwr[i] && m_mux[i]) begin oe = alt_oe[i]; v = alt_out[i]; end
            3'd3, 3'd4, 3'd5: begin
                if (rel && m_en[i]) begin oe = soe; v = sval; end
                else if (rel) begin
                    oe = 1'b1;
                    v  = (g == 3'd4) ? 1'b1 : (g == 3'd5) ? ((i % 2) == 1) : 1'b0;
                end
            end
            default: if (rel && m_en[i]) begin oe = soe; v = sval; end
        endcase
        return {oe, oe & v};
    endfunction

    task automatic check_pads(input logic rel);
        for (int i = 0; i < NP; i++) begin
            check(req_of(GRP[i]), {30'd0, pad_oe[i], pad_out[i]}, {30'd0, model(i, rel)});
        end
    endtask

    // release all sources and walk the reset-out window
    task automatic release_and_check(input logic [NP-1:0] straps, input logic [NP-1:0] exp_cfg);
        pad_in    = straps;
        rst_src_n = '1;
        repeat (5) tick();
        wr(2'd2, '1);                     // R11: attempt during hold, must be dropped
        repeat (H + 2 - 6) tick();
        check("R2 rstout low at edge H+2", {31'd0, rstout_n}, 32'd0);
        check("R4 strap pad floats in hold", {31'd0, pad_oe[1]}, 32'd0);
        tick();
        check("R2 rstout high at edge H+3", {31'd0, rstout_n}, 32'd1);
        check("R5 cfg not yet loaded", {22'd0, cfg_word}, 32'd0);
        m_mux = '0; m_pwr = '0; m_en = '0;
        check_pads(1'b1);                 // R8 R9 R10 R11: held drives, write dropped
        tick();
        check("R5 cfg loaded", {22'd0, cfg_word}, {22'd0, exp_cfg});
    endtask

    initial begin
        rst_src_n = '0;
        for (int i = 0; i < NP; i++) pad_group[3*i +: 3] = GRP[i];
        pad_in   = '0;
        dflt_oe  = 10'h3FF;
        dflt_out = 10'h2A5;
        alt_oe   = 10'h3FF;
        alt_out  = 10'h3FF;
        wr_en    = 1'b0;
        wr_sel   = 2'd0;
        wr_data  = '0;
        m_mux = '0; m_pwr = '0; m_en = '0;

        repeat (3) tick();
        check("R1 rstout low in reset", {31'd0, rstout_n}, 32'd0);
        check("R1 held pads undriven", {22'd0, pad_oe & 10'h3FE}, 32'd0);
        check("R3 default pad follows default", {30'd0, pad_oe[0], pad_out[0]}, {30'd0, 1'b1, 1'b1});
        check("R5 cfg zero in reset", {22'd0, cfg_word}, 32'd0);

        release_and_check(10'h3C2, 10'h082);

        pad_in = 10'h000;                 // R6
        repeat (5) tick();
        check("R6 cfg held", {22'd0, cfg_word}, 32'h082);

        for (int v = 0; v < NV; v++) begin
            {m_mux, m_pwr, m_en, dflt_oe, dflt_out, alt_oe, alt_out} = VEC[v];
            wr(2'd0, m_mux);
            wr(2'd1, m_pwr);
            wr(2'd3, '1);                 // R11: unused select changes nothing
            wr(2'd2, m_en);               // R11: visible right after this edge
            check_pads(1'b1);
        end

        // second reset from another source, asserted between edges
        rst_src_n = 3'b011;
        #1;
        check("R1 async rstout", {31'd0, rstout_n}, 32'd0);
        check("R1 async held pads", {22'd0, pad_oe & 10'h3FE}, 32'd0);
        check("R5 async cfg clear", {22'd0, cfg_word}, 32'd0);
        check("R3 default pad in reset", {30'd0, pad_oe[0], pad_out[0]}, {30'd0, dflt_oe[0], dflt_oe[0] & dflt_out[0]});
        repeat (3) tick();
        release_and_check(10'h3FD, 10'h080);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule